// File: doc/BRIEF.md
# Status Change Interrupt Controller

This block watches a vector of internal status bits and raises interrupt requests whenever any of those bits changes value. A rising or a falling change of a bit sets that bit's sticky raw flag. The raw flag then stays set until software clears it by writing a one to it. Two request outputs exist, and each has its own enable mask over the raw flags. A request is asserted while any raw flag that its mask enables is set.

The main request drives a dedicated pin. The auxiliary request has no pin of its own. A control field steers it onto one of three shared pins:
- an audio bit-clock pin,
- an audio reference-clock pin,
- a hot-plug signalling pin.

Each shared pin carries its normal function whenever it is not selected. Each request has its own programmable polarity. Software reaches the masks, the flags and the control field through a simple register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `stchg_irq_ctrl`

## Requirements
- R1: After reset all raw flags, both masks and the control register read as zero. The main request idles high, because polarity 0 means active-low. Route 0 selects no pin, so all three shared pins carry their functional inputs.
- R2: A status bit that differs from its value at the previous clock edge sets its raw flag (address 0) at that edge, whether the change is rising or falling and whether the bit is enabled or not.
- R3: The status value present while reset is held, or at the first edge after reset is released, never sets a flag. Only changes after that first edge count.
- R4: Writing to address 0 clears each raw flag whose write-data bit is 1 and leaves the other flags unchanged.
- R5: When a write-one-to-clear and a new change hit the same bit in the same cycle, the flag stays set.
- R6: Address 3 reads the main pending flags (raw AND mask A). The main request is asserted exactly when this value is nonzero.
- R7: Address 2 holds mask B. Address 4 reads the auxiliary pending flags (raw AND mask B). These are independent of mask A.
- R8: In the control register at address 5, bit 0 sets the main polarity and bit 1 sets the auxiliary polarity, with 1 meaning active-high and 0 meaning active-low. A request with nothing pending drives the inactive level.
- R9: Control bits [3:2] select the auxiliary route: 0 selects no pin, 1 the audio bit-clock pin, 2 the audio reference-clock pin, 3 the hot-plug pin. The selected pin shows the auxiliary request level. Every other shared pin carries its functional input.
- R10: Masks A and B (addresses 1 and 2) and the control register read back what was written. Writes to addresses 3, 4, 6 and 7 change nothing. Addresses 6 and 7 read as zero.
- R11: A flag latched while its bit was disabled asserts the request as soon as the mask enables it, with no new change needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | NSTAT | Monitored status bits |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for read and write |
| reg_wdata_i | input | NSTAT | Register write data |
| reg_rdata_o | output | NSTAT | Register read data (combinational) |
| aud_bitclk_i | input | 1 | Functional signal for the audio bit-clock pin |
| aud_refclk_i | input | 1 | Functional signal for the audio reference-clock pin |
| hotplug_i | input | 1 | Functional signal for the hot-plug pin |
| irq_main_o | output | 1 | Main interrupt request, dedicated pin |
| pin_aud_bitclk_o | output | 1 | Shared audio bit-clock pin |
| pin_aud_refclk_o | output | 1 | Shared audio reference-clock pin |
| pin_hotplug_o | output | 1 | Shared hot-plug pin |

NSTAT defaults to 8 and must be at least 4.

## Verification
The hardest case to reach from the ports is a clear and a new change landing on the same flag in the same cycle. The stimulus table produces it by stepping a status bit in the same vector that writes a one to that bit's flag, so both reach the flag register at one edge. A second hard case is a flag that was captured while its bit was masked and is enabled only later. The table latches it with the mask off, then widens the mask without touching the status bits. The auxiliary routing is checked with the functional inputs flipped before each readout, so that a pass-through cannot be mistaken for a steered request.

// File: rtl/stchg_pkg.sv
`timescale 1ns/1ps
package stchg_pkg;

    localparam int ADDR_W = 3;
    localparam int NPIN   = 3;
    localparam int CTRL_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_RAW    = 3'd0,
        REG_MASK_A = 3'd1,
        REG_MASK_B = 3'd2,
        REG_PEND_A = 3'd3,
        REG_PEND_B = 3'd4,
        REG_CTRL   = 3'd5
    } reg_addr_e;

    // Route code k (k >= 1) selects shared pin index k-1.
    typedef enum logic [1:0] {
        RT_NONE    = 2'd0,
        RT_BITCLK  = 2'd1,
        RT_REFCLK  = 2'd2,
        RT_HOTPLUG = 2'd3
    } route_e;

    typedef struct packed {
        route_e route;   // bits [3:2]
        logic   pol_b;   // bit 1
        logic   pol_a;   // bit 0
    } ctrl_t;

endpackage

// File: rtl/stchg_change_det.sv
`timescale 1ns/1ps
module stchg_change_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] status_i,
    output logic [W-1:0] chg_o
);

    typedef struct packed {
        logic [W-1:0] prev;
        logic         armed;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.prev  = status_i;
        st_d.armed = 1'b1;
        // Nothing counts until one sample has been taken after reset.
        chg_o      = st_q.armed ? (status_i ^ st_q.prev) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/stchg_flag_bank.sv
`timescale 1ns/1ps
module stchg_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] raw_o
);

    typedef struct packed {
        logic [W-1:0] raw;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // Set after clear: a fresh change beats a simultaneous acknowledge.
        st_d.raw = (st_q.raw & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o = st_q.raw;

    assert_change_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((raw_o & $past(set_i)) == $past(set_i)));

    assert_no_spurious_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_o & ~$past(raw_o) & ~$past(set_i)) == '0));

    assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((raw_o & $past(clr_i & ~set_i)) == '0));

    assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & set_i) != '0) |=> ((raw_o & $past(clr_i & set_i)) == $past(clr_i & set_i)));

endmodule

// File: rtl/stchg_regs.sv
`timescale 1ns/1ps
module stchg_regs
    import stchg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      raw_i,
    output logic [W-1:0]      rdata_o,
    output logic [W-1:0]      clr_o,
    output logic [W-1:0]      pend_a_o,
    output logic [W-1:0]      pend_b_o,
    output ctrl_t             ctrl_o
);

    typedef struct packed {
        logic [W-1:0] mask_a;
        logic [W-1:0] mask_b;
        ctrl_t        ctrl;
    } regs_t;

    regs_t st_d, st_q;
    reg_addr_e addr_e;

    assign addr_e = reg_addr_e'(addr_i);

    always_comb begin
        st_d  = st_q;
        clr_o = '0;
        if (we_i) begin
            case (addr_e)
                REG_RAW:    clr_o       = wdata_i;
                REG_MASK_A: st_d.mask_a = wdata_i;
                REG_MASK_B: st_d.mask_b = wdata_i;
                REG_CTRL:   st_d.ctrl   = ctrl_t'(wdata_i[CTRL_W-1:0]);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_a_o = raw_i & st_q.mask_a;
    assign pend_b_o = raw_i & st_q.mask_b;
    assign ctrl_o   = st_q.ctrl;

    always_comb begin
        case (addr_e)
            REG_RAW:    rdata_o = raw_i;
            REG_MASK_A: rdata_o = st_q.mask_a;
            REG_MASK_B: rdata_o = st_q.mask_b;
            REG_PEND_A: rdata_o = pend_a_o;
            REG_PEND_B: rdata_o = pend_b_o;
            REG_CTRL:   rdata_o = W'(st_q.ctrl);
            default:    rdata_o = '0;
        endcase
    end

    assert_ro_write_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (addr_i == 3'(REG_PEND_A) || addr_i == 3'(REG_PEND_B) || addr_i[2:1] == 2'b11))
        |=> (st_q == $past(st_q)));

    assert_raw_write_keeps_cfg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == 3'(REG_RAW)) |=> (st_q == $past(st_q)));

endmodule

// File: rtl/stchg_pin_route.sv
`timescale 1ns/1ps
module stchg_pin_route
    import stchg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    pend_a_i,
    input  logic [W-1:0]    pend_b_i,
    input  ctrl_t           ctrl_i,
    input  logic [NPIN-1:0] func_i,
    output logic            irq_main_o,
    output logic [NPIN-1:0] pin_o
);

    logic lvl_b;

    // Polarity 1 = active-high, 0 = active-low.
    assign irq_main_o = ctrl_i.pol_a ? (|pend_a_i) : ~(|pend_a_i);
    assign lvl_b      = ctrl_i.pol_b ? (|pend_b_i) : ~(|pend_b_i);

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign pin_o[g] = (ctrl_i.route == route_e'(2'(g + 1))) ? lvl_b : func_i[g];
    end

endmodule

// File: rtl/stchg_irq_ctrl.sv
`timescale 1ns/1ps
module stchg_irq_ctrl
    import stchg_pkg::*;
#(
    parameter int NSTAT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSTAT-1:0]  status_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [NSTAT-1:0]  reg_wdata_i,
    output logic [NSTAT-1:0]  reg_rdata_o,
    input  logic              aud_bitclk_i,
    input  logic              aud_refclk_i,
    input  logic              hotplug_i,
    output logic              irq_main_o,
    output logic              pin_aud_bitclk_o,
    output logic              pin_aud_refclk_o,
    output logic              pin_hotplug_o
);

    logic [NSTAT-1:0] chg, raw, clr, pend_a, pend_b;
    logic [NPIN-1:0]  func_vec, pin_vec;
    ctrl_t            ctrl;

    // Shared pin index order matches route codes 1..3.
    assign func_vec = {hotplug_i, aud_refclk_i, aud_bitclk_i};
    assign {pin_hotplug_o, pin_aud_refclk_o, pin_aud_bitclk_o} = pin_vec;

    stchg_change_det #(.W(NSTAT)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_i),
        .chg_o    (chg)
    );

    stchg_flag_bank #(.W(NSTAT)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (chg),
        .clr_i (clr),
        .raw_o (raw)
    );

    stchg_regs #(.W(NSTAT)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (reg_we_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i),
        .raw_i    (raw),
        .rdata_o  (reg_rdata_o),
        .clr_o    (clr),
        .pend_a_o (pend_a),
        .pend_b_o (pend_b),
        .ctrl_o   (ctrl)
    );

    stchg_pin_route #(.W(NSTAT)) u_route (
        .pend_a_i   (pend_a),
        .pend_b_i   (pend_b),
        .ctrl_i     (ctrl),
        .func_i     (func_vec),
        .irq_main_o (irq_main_o),
        .pin_o      (pin_vec)
    );

    assert_idle_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == '0) |-> (irq_main_o == ~ctrl.pol_a));

    assert_unrouted_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.route == RT_NONE) |-> (pin_vec == func_vec));

    assert_single_pin_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pin_vec ^ func_vec) <= 1);

endmodule

// File: tb/stchg_irq_ctrl_tb.sv
`timescale 1ns/1ps
module stchg_irq_ctrl_tb;

    localparam int W  = 8;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] status = '0;
    logic         we = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         f_bit = 1'b0, f_ref = 1'b1, f_hot = 1'b0;
    logic         irq_main, p_bit, p_ref, p_hot;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stchg_irq_ctrl #(.NSTAT(W)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .status_i         (status),
        .reg_we_i         (we),
        .reg_addr_i       (addr),
        .reg_wdata_i      (wdata),
        .reg_rdata_o      (rdata),
        .aud_bitclk_i     (f_bit),
        .aud_refclk_i     (f_ref),
        .hotplug_i        (f_hot),
        .irq_main_o       (irq_main),
        .pin_aud_bitclk_o (p_bit),
        .pin_aud_refclk_o (p_ref),
        .pin_hotplug_o    (p_hot)
    );

    // {status[31:24], we[23], waddr[22:20], wdata[19:12], raddr[11:9], exp_rdata[8:1], exp_irq_main[0]}
    localparam logic [31:0] VEC [NV] = '{
        {8'h00, 1'b1, 3'd1, 8'h0F, 3'd1, 8'h0F, 1'b1},  // 0  R10 mask A readback, idle high
        {8'h01, 1'b0, 3'd0, 8'h00, 3'd0, 8'h01, 1'b0},  // 1  R2 rising change
        {8'h11, 1'b0, 3'd0, 8'h00, 3'd0, 8'h11, 1'b0},  // 2  R11 disabled bit latched
        {8'h10, 1'b1, 3'd0, 8'h01, 3'd0, 8'h11, 1'b0},  // 3  R5 set beats clear
        {8'h10, 1'b1, 3'd0, 8'h01, 3'd3, 8'h00, 1'b1},  // 4  R4 clear one bit
        {8'h10, 1'b1, 3'd1, 8'h1F, 3'd3, 8'h10, 1'b0},  // 5  R11 late enable
        {8'h10, 1'b1, 3'd0, 8'hFF, 3'd0, 8'h00, 1'b1},  // 6  R4 clear all
        {8'h10, 1'b1, 3'd5, 8'h01, 3'd5, 8'h01, 1'b0},  // 7  R8 main active-high
        {8'h90, 1'b0, 3'd0, 8'h00, 3'd0, 8'h80, 1'b0},  // 8  R6 unmasked flag no request
        {8'h90, 1'b1, 3'd2, 8'h80, 3'd4, 8'h80, 1'b0},  // 9  R7 mask B pending
        {8'h90, 1'b1, 3'd3, 8'hFF, 3'd3, 8'h00, 1'b0},  // 10 R10 RO write
        {8'h90, 1'b1, 3'd4, 8'hFF, 3'd1, 8'h1F, 1'b0},  // 11 R10 RO write
        {8'h80, 1'b0, 3'd0, 8'h00, 3'd3, 8'h10, 1'b1},  // 12 R2 falling change
        {8'h80, 1'b1, 3'd0, 8'h90, 3'd0, 8'h00, 1'b0},  // 13 R4 clear
        {8'h80, 1'b1, 3'd6, 8'hFF, 3'd6, 8'h00, 1'b0},  // 14 R10 unmapped
        {8'h80, 1'b0, 3'd0, 8'h00, 3'd5, 8'h01, 1'b0}   // 15 R10 ctrl readback
    };

    function automatic string vec_tag(input int i);
        case (i)
            1, 12:         return "R2";
            2, 5:          return "R11";
            3:             return "R5";
            4, 6, 13:      return "R4";
            7:             return "R8";
            8:             return "R6";
            9:             return "R7";
            default:       return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
        addr = a;
        #1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    task automatic set_st(input logic [W-1:0] v);
        @(negedge clk);
        status = v;
        @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd("R1", 3'd0, 8'h00);
        rd("R1", 3'd1, 8'h00);
        rd("R1", 3'd2, 8'h00);
        rd("R1", 3'd5, 8'h00);
        chk("R1", 32'(irq_main), 32'd1);
        chk("R1", 32'({p_hot, p_ref, p_bit}), 32'({f_hot, f_ref, f_bit}));

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            @(negedge clk);
            status = v[31:24]; we = v[23]; addr = v[22:20]; wdata = v[19:12];
            @(negedge clk);
            we = 1'b0; addr = v[11:9];
            #1;
            chk(vec_tag(i), 32'(rdata), 32'(v[8:1]));
            chk(vec_tag(i), 32'(irq_main), 32'(v[0]));
        end

        // R9 unrouted pins pass both functional levels
        chk("R9", 32'({p_hot, p_ref, p_bit}), 32'b010);
        f_bit = 1'b1; f_ref = 1'b0; f_hot = 1'b1;
        #1;
        chk("R9", 32'({p_hot, p_ref, p_bit}), 32'b101);

        // route to bit-clock pin, both polarities high
        wr(3'd5, 8'h07);
        #1;
        chk("R8", 32'(p_bit), 32'd0);
        chk("R9", 32'({p_hot, p_ref}), 32'b10);
        set_st(8'h00);
        chk("R9", 32'(p_bit), 32'd1);
        chk("R6", 32'(irq_main), 32'd0);

        // route to reference-clock pin
        wr(3'd5, 8'h0B);
        f_bit = 1'b0;
        #1;
        chk("R9", 32'(p_ref), 32'd1);
        chk("R9", 32'(p_bit), 32'd0);
        wr(3'd5, 8'h09);
        #1;
        chk("R8", 32'(p_ref), 32'd0);

        // route to hot-plug pin, active-low
        wr(3'd5, 8'h0D);
        f_ref = 1'b1;
        #1;
        chk("R9", 32'(p_hot), 32'd0);
        chk("R9", 32'(p_ref), 32'd1);
        wr(3'd0, 8'h80);
        #1;
        chk("R8", 32'(p_hot), 32'd1);

        // R3 status held through reset does not flag
        @(negedge clk);
        rst_n = 1'b0; status = 8'hAA;
        @(negedge clk);
        rd("R1", 3'd1, 8'h00);
        chk("R1", 32'(irq_main), 32'd1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        rd("R3", 3'd0, 8'h00);
        set_st(8'hAB);
        rd("R3", 3'd0, 8'h01);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule